// File: doc/BRIEF.md
# Masked Trigger Comparator with Serial Configuration

This block checks each sample of a 24-channel capture against a programmable pattern. A mask sets, bit by bit, which channels take part in the check. Channels whose mask bit is clear are don't-care. When every channel that takes part agrees with the pattern, the block raises a trigger pulse for one sample clock. The rest of the analyzer uses that pulse to start its post-trigger count.

All settings travel over a two-wire serial link: a serial clock and a serial data line. The analyzer clock oversamples both lines. Bits go into a 60-bit internal shift chain, and this chain is separate from the settings the analyzer currently uses. The chain is copied to the parallel outputs only while the initialise input is high, so a new word can be shifted in during a capture without disturbing it. The word also carries the acquisition settings: edge polarity, clock source, prescaler, divider enables and post-trigger delay. The block presents these settings as parallel outputs.

Top module: `trig_cfg_match`

## Requirements
- R1: While `rstN` is low, every configuration output and `trigPulse` read 0.
- R2: Each rising edge of `cfgSck` shifts one `cfgSdi` bit into the chain, most significant bit first. After exactly 60 rising edges, the first bit sent is the top bit of the word. Falling edges shift nothing.
- R3: Word layout from bit 59 down to bit 0: `edgePol` [59], `clkSrc` [58:57], `prescSel` [56:54], `divEn` [53:51], `delaySel` [50:48], `trigMask` [47:24], `trigPattern` [23:0].
- R4: The parallel outputs take the shift chain's value only on clock edges where `initReq` is high. At all other times they hold, whatever is shifted in.
- R5: A clock edge with `initReq` high disarms the comparator. A later edge with `armReq` high and `initReq` low arms it.
- R6: While armed, a sample in which every masked-in bit equals its pattern bit raises `trigPulse` on the next clock edge.
- R7: A channel whose `trigMask` bit is 0 never prevents a match, whatever its sample value.
- R8: `trigPulse` is high for exactly one cycle, and only for the first match after arming. Later matches, and `armReq` edges, do nothing until `initReq` is asserted again.
- R9: With `trigMask` all zero, the first sample taken while armed triggers.
- R10: While not armed, no sample raises `trigPulse`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cfgSck | input | 1 | Serial configuration clock, oversampled |
| cfgSdi | input | 1 | Serial configuration data |
| initReq | input | 1 | Initialise: copy the settings, disarm |
| armReq | input | 1 | Arm the comparator |
| sampleIn | input | 24 | Captured channel sample |
| edgePol | output | 1 | Active sample edge setting |
| clkSrc | output | 2 | Clock source setting |
| prescSel | output | 3 | Prescaler setting |
| divEn | output | 3 | Divider enables |
| delaySel | output | 3 | Post-trigger delay setting |
| trigMask | output | 24 | Per-channel compare enable |
| trigPattern | output | 24 | Compare pattern |
| trigPulse | output | 1 | One-cycle trigger |

## Verification
The hardest case to reach is a match that arrives after the trigger has already fired, or while a new word sits in the shift chain but has not yet been copied out. Both need a full 60-bit serial load followed by a carefully timed sequence of initialise, arm and sample. The bench therefore shifts a second word during the capture and checks that the outputs hold. It then re-arms without initialising and sends further matching samples, expecting no pulse. Random samples, a quarter of them forced to match on the masked-in bits, are checked against a model in the bench over several masks, including an all-zero mask and a full mask.

// File: rtl/trig_cfg_pkg.sv
package trig_cfg_pkg;
  localparam int unsigned HDR_W = 12;

  typedef struct packed {
    logic shiftEn;
    logic shiftBit;
    logic loadCfg;
    logic compareEn;
  } ctlStrobe_t;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ARMED = 2'd1,
    ST_DONE  = 2'd2
  } armState_t;
endpackage

// File: rtl/trig_ctl.sv
module trig_ctl
  import trig_cfg_pkg::*;
#(
  parameter int unsigned SYNC_N = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       cfgSck,
  input  logic       cfgSdi,
  input  logic       initReq,
  input  logic       armReq,
  input  logic       matchNow,
  output ctlStrobe_t strb
);
  localparam int unsigned SCK_N = SYNC_N + 1;

  logic [SCK_N-1:0]  sckSync;
  logic [SYNC_N-1:0] sdiSync;
  armState_t         state;
  armState_t         stateNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sckSync <= '0;
      sdiSync <= '0;
    end else begin
      sckSync <= {sckSync[SCK_N-2:0], cfgSck};
      sdiSync <= {sdiSync[SYNC_N-2:0], cfgSdi};
    end
  end

  always_comb begin
    stateNext = state;
    if (initReq)                             stateNext = ST_IDLE;
    else if (state == ST_IDLE && armReq)     stateNext = ST_ARMED;
    else if (state == ST_ARMED && matchNow)  stateNext = ST_DONE;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    strb.shiftEn   = sckSync[SCK_N-2] & ~sckSync[SCK_N-1];
    strb.shiftBit  = sdiSync[SYNC_N-1];
    strb.loadCfg   = initReq;
    strb.compareEn = (state == ST_ARMED) & ~initReq;
  end

  // R8: once fired, the comparator never goes straight back to armed
  assert_no_rearm_R8: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_DONE && !initReq) |=> (state != ST_ARMED));

  // R5: initialise always leaves the comparator disarmed
  assert_init_disarms_R5: assert property (@(posedge clk) disable iff (!rstN)
    initReq |=> (state == ST_IDLE));
endmodule

// File: rtl/trig_dp.sv
module trig_dp
  import trig_cfg_pkg::*;
#(
  parameter int unsigned CHAN_W = 24,
  localparam int unsigned CFG_W = HDR_W + 2 * CHAN_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobe_t        strb,
  input  logic [CHAN_W-1:0] sampleIn,
  output logic [CFG_W-1:0]  cfgWord,
  output logic              matchNow,
  output logic              trigPulse
);
  logic [CFG_W-1:0]  shiftChain;
  logic [CHAN_W-1:0] bitHit;
  logic [CHAN_W-1:0] maskCur;
  logic [CHAN_W-1:0] patCur;

  assign maskCur = cfgWord[2*CHAN_W-1:CHAN_W];
  assign patCur  = cfgWord[CHAN_W-1:0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             shiftChain <= '0;
    else if (strb.shiftEn) shiftChain <= {shiftChain[CFG_W-2:0], strb.shiftBit};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             cfgWord <= '0;
    else if (strb.loadCfg) cfgWord <= shiftChain;
  end

  for (genvar i = 0; i < CHAN_W; i++) begin : g_bit
    assign bitHit[i] = ~maskCur[i] | ~(sampleIn[i] ^ patCur[i]);
  end

  assign matchNow = &bitHit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) trigPulse <= 1'b0;
    else       trigPulse <= strb.compareEn & matchNow;
  end

  // R4: settings hold on every edge without initialise
  assert_cfg_hold_R4: assert property (@(posedge clk) disable iff (!rstN)
    !strb.loadCfg |=> $stable(cfgWord));

  // R8: the pulse lasts one cycle
  assert_pulse_single_R8: assert property (@(posedge clk) disable iff (!rstN)
    trigPulse |=> !trigPulse);

  // R10: a pulse needs the comparator to have been armed on the prior edge
  assert_pulse_armed_R10: assert property (@(posedge clk) disable iff (!rstN)
    trigPulse |-> $past(strb.compareEn));

  // R9: an empty mask fires on the first armed sample
  assert_empty_mask_R9: assert property (@(posedge clk) disable iff (!rstN)
    (strb.compareEn && maskCur == '0) |=> trigPulse);
endmodule

// File: rtl/trig_cfg_match.sv
module trig_cfg_match
  import trig_cfg_pkg::*;
#(
  parameter int unsigned CHAN_W = 24,
  parameter int unsigned SYNC_N = 2,
  localparam int unsigned CFG_W = HDR_W + 2 * CHAN_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgSck,
  input  logic              cfgSdi,
  input  logic              initReq,
  input  logic              armReq,
  input  logic [CHAN_W-1:0] sampleIn,
  output logic              edgePol,
  output logic [1:0]        clkSrc,
  output logic [2:0]        prescSel,
  output logic [2:0]        divEn,
  output logic [2:0]        delaySel,
  output logic [CHAN_W-1:0] trigMask,
  output logic [CHAN_W-1:0] trigPattern,
  output logic              trigPulse
);
  ctlStrobe_t       strb;
  logic [CFG_W-1:0] cfgWord;
  logic             matchNow;

  trig_ctl #(.SYNC_N(SYNC_N)) u_ctl (
    .clk      (clk),
    .rstN     (rstN),
    .cfgSck   (cfgSck),
    .cfgSdi   (cfgSdi),
    .initReq  (initReq),
    .armReq   (armReq),
    .matchNow (matchNow),
    .strb     (strb)
  );

  trig_dp #(.CHAN_W(CHAN_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .sampleIn  (sampleIn),
    .cfgWord   (cfgWord),
    .matchNow  (matchNow),
    .trigPulse (trigPulse)
  );

  assign edgePol     = cfgWord[CFG_W-1];
  assign clkSrc      = cfgWord[CFG_W-2 -: 2];
  assign prescSel    = cfgWord[CFG_W-4 -: 3];
  assign divEn       = cfgWord[CFG_W-7 -: 3];
  assign delaySel    = cfgWord[CFG_W-10 -: 3];
  assign trigMask    = cfgWord[2*CHAN_W-1:CHAN_W];
  assign trigPattern = cfgWord[CHAN_W-1:0];
endmodule

// File: tb/trig_cfg_match_test.sv
module trig_cfg_match_test;
  localparam int CLK_PERIOD = 10;
  localparam int CW = 24;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cfgSck = 1'b0, cfgSdi = 1'b0, initReq = 1'b0, armReq = 1'b0;
  logic [CW-1:0] sampleIn = '0;
  logic edgePol, trigPulse;
  logic [1:0] clkSrc;
  logic [2:0] prescSel, divEn, delaySel;
  logic [CW-1:0] trigMask, trigPattern;

  int vecCnt = 0;
  int failCnt = 0;
  bit modelArmed = 0;
  bit modelFired = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  trig_cfg_match uut (
    .clk(clk), .rstN(rstN), .cfgSck(cfgSck), .cfgSdi(cfgSdi),
    .initReq(initReq), .armReq(armReq), .sampleIn(sampleIn),
    .edgePol(edgePol), .clkSrc(clkSrc), .prescSel(prescSel), .divEn(divEn),
    .delaySel(delaySel), .trigMask(trigMask), .trigPattern(trigPattern),
    .trigPulse(trigPulse)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    vecCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic waitCyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // R2: one bit per rising cfgSck edge, top bit first
  task automatic shiftWord(input logic [59:0] w);
    for (int i = 59; i >= 0; i--) begin
      cfgSdi = w[i];
      waitCyc(3);
      cfgSck = 1'b1;
      waitCyc(3);
      cfgSck = 1'b0;
      waitCyc(3);
    end
  endtask

  task automatic doInit();
    initReq = 1'b1;
    waitCyc(1);
    initReq = 1'b0;
    modelArmed = 0;
    modelFired = 0;
  endtask

  task automatic doArm();
    armReq = 1'b1;
    waitCyc(1);
    armReq = 1'b0;
    if (!modelFired) modelArmed = 1;
  endtask

  task automatic checkFields(input string tag, input logic [59:0] w);
    check({tag, " pol"},  64'(edgePol),     64'(w[59]));
    check({tag, " src"},  64'(clkSrc),      64'(w[58:57]));
    check({tag, " pre"},  64'(prescSel),    64'(w[56:54]));
    check({tag, " div"},  64'(divEn),       64'(w[53:51]));
    check({tag, " dly"},  64'(delaySel),    64'(w[50:48]));
    check({tag, " mask"}, 64'(trigMask),    64'(w[47:24]));
    check({tag, " pat"},  64'(trigPattern), 64'(w[23:0]));
  endtask

  // R6 R7 R8 R10: expected pulse from the bench model
  task automatic applySample(input string tag, input logic [CW-1:0] s,
                             input logic [CW-1:0] m, input logic [CW-1:0] p);
    bit hit;
    bit exp;
    sampleIn = s;
    hit = (((s ~^ p) | ~m) == {CW{1'b1}});
    exp = modelArmed && !modelFired && hit;
    @(posedge clk);
    @(negedge clk);
    if (exp) begin
      modelFired = 1;
      modelArmed = 0;
    end
    check(tag, 64'(trigPulse), 64'(exp));
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    failCnt++;
    $display("FAIL watchdog actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vecCnt, failCnt);
    $finish;
  end

  initial begin
    logic [59:0] w;
    logic [59:0] w2;
    logic [CW-1:0] m, p, s;

    waitCyc(3);
    // R1: reset state
    check("R1 cfg", 64'({edgePol, clkSrc, prescSel, divEn, delaySel, trigMask, trigPattern}), 64'd0);
    check("R1 pulse", 64'(trigPulse), 64'd0);
    rstN = 1'b1;
    waitCyc(2);

    for (int k = 0; k < 6; k++) begin
      m = (k == 0) ? '1 : (k == 1) ? '0 : CW'($urandom);
      p = CW'($urandom);
      w = {12'($urandom), m, p};
      shiftWord(w);
      doInit();
      checkFields("R2 R3 load", w);
      // R10: not armed, matching samples give nothing
      applySample("R10 unarmed", p, m, p);
      applySample("R10 unarmed", (CW'($urandom) & ~m) | (p & m), m, p);
      doArm();
      if (k == 1) applySample("R9 empty mask", CW'($urandom), m, p);
      for (int j = 0; j < 40; j++) begin
        s = CW'($urandom);
        if (j % 4 == 3) s = (s & ~m) | (p & m);
        applySample("R6 R8 sweep", s, m, p);
      end
      applySample("R8 after fire", p, m, p);
    end

    // R7: a clear mask bit is don't-care, a set one is not
    m = ~CW'(1); p = 24'h5A3C96;
    w = {12'hA5C, m, p};
    shiftWord(w);
    doInit();
    doArm();
    applySample("R7 enabled bit differs", p ^ CW'(2), m, p);
    applySample("R7 masked bit differs", p ^ CW'(1), m, p);
    check("R7 fired", 64'(modelFired), 64'd1);

    // R4: shift a new word without initialise, outputs hold
    w2 = ~w;
    shiftWord(w2);
    checkFields("R4 hold", w);
    // R8: re-arm without initialise does nothing
    doArm();
    modelArmed = 0;
    modelFired = 1;
    applySample("R8 rearm ignored", p, m, p);
    doInit();
    checkFields("R4 update", w2);

    // R5: initialise between arm and match disarms
    doArm();
    doInit();
    applySample("R5 disarmed", w2[23:0], w2[47:24], w2[23:0]);
    doArm();
    applySample("R5 rearmed", w2[23:0], w2[47:24], w2[23:0]);

    $display("== %0d vectors applied, %0d miscompares ==", vecCnt, failCnt);
    $finish;
  end
endmodule